// File: doc/BRIEF.md
# Double-Buffered Virtual-Channel Slot Allocation Table

This block keeps the time-slot allocation for up to four virtual channels that share one multi-stream link. Each table entry names a source stream and the number of time slots that stream owns in every transport frame. Software fills a shadow copy of the table one entry at a time. It then issues an update command. The shadow copy becomes active only through that command, so the link never sees a half-written allocation.

An update can take one of two forms. The first raises a trigger request, which asks the link layer to announce the allocation change, and waits for a done pulse before it arms the copy. The second arms the copy at once. In both forms the copy lands on the next frame boundary, and a pending flag covers the whole interval. The active table is laid out over a 64-slot frame. Slot 0 carries the frame header. Entries take contiguous runs of slots in entry order, starting at slot 1. In every slot the block reports which channel, and which source stream, owns that slot.

Top module: `slot_alloc_table`

## Requirements
- R1: Driving `shd_we` high writes `shd_src` and `shd_cnt` into shadow entry `shd_idx` (0 to 3). Shadow contents reach the active outputs `act_src`/`act_cnt` (entry i in bits [i*W +: W]) only through a commit.
- R2: After reset, every active entry holds source 0 and count 0. `pending` and `trig_req` are low and the slot index is 0.
- R3: `upd_cmd` encoding: 2'd1 means update with trigger, 2'd2 means update without trigger. 2'd0 and 2'd3 take no action and leave `pending` low.
- R4: `pending` rises one cycle after an accepted command. It stays high up to and including the cycle of the clock edge that loads the active table, and it is low after that edge.
- R5: With command 1, `trig_req` is high from the cycle after the command until the edge that samples `trig_done` high. The active table does not change while `trig_req` is high.
- R6: The copy happens on the first frame boundary after the arming point. A frame boundary is an edge where `slot_adv` is high and the slot index is 63. The arming point is the done edge for command 1, or the command edge for command 2. A boundary on the done edge itself does not count.
- R7: A command of 1 or 2 issued while `pending` is high is ignored.
- R8: Each edge with `slot_adv` high advances `slot_idx` by one, wrapping from 63 to 0. In slot 0, `hdr_slot` is high and `owner_vld` is low.
- R9: Entry i owns slots 1+sum(cnt[0..i-1]) up to, but not including, that start plus cnt[i]. In an owned slot, `owner_vld` is high and `owner_vc`/`owner_src` give the entry number and its source. In any other slot, `owner_vld` is low.
- R10: Runs that reach past slot 63 are clipped at the frame end. `alloc_err` is high whenever the active counts add up to more than 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shd_we | input | 1 | Shadow entry write strobe |
| shd_idx | input | 2 | Shadow entry number |
| shd_src | input | 2 | Source stream index to write |
| shd_cnt | input | 6 | Slot count to write |
| upd_cmd | input | 2 | Update command (0 none, 1 trigger, 2 direct, 3 none) |
| trig_done | input | 1 | Pulse: allocation-change trigger has been sent |
| slot_adv | input | 1 | Advance to the next time slot |
| pending | output | 1 | Update in progress |
| trig_req | output | 1 | Request to send the allocation-change trigger |
| act_src | output | 8 | Active source indexes, entry i in [2i+1:2i] |
| act_cnt | output | 24 | Active slot counts, entry i in [6i+5:6i] |
| slot_idx | output | 6 | Current slot within the frame |
| hdr_slot | output | 1 | Current slot is the header slot |
| owner_vld | output | 1 | Current slot is allocated |
| owner_vc | output | 2 | Entry owning the current slot |
| owner_src | output | 2 | Source stream owning the current slot |
| alloc_err | output | 1 | Active counts exceed 63 slots |

## Verification
`pending` and `trig_req` change one edge after the command or done input that moves them. The active table, `pending`'s fall and the new slot map all appear right after the boundary edge. The owner outputs are combinational from the slot index and the active table, so they are valid in the same cycle as `slot_idx`. The bench updates a reference model on each rising edge from the inputs it drove at the previous falling edge. It compares every output against that model at the next falling edge, which puts each check exactly one edge after its cause.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    UPD_NONE   = 2'd0,
    UPD_TRIG   = 2'd1,
    UPD_DIRECT = 2'd2,
    UPD_RSVD   = 2'd3
  } upd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TRIG = 2'd1,
    ST_ARM  = 2'd2
  } commit_st_e;
endpackage

// File: rtl/sat_shadow.sv
module sat_shadow #(
  parameter int NUM_VC = 4,
  parameter int SRC_W  = 2,
  parameter int SLOT_W = 6,
  localparam int IDX_W = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  logic [SRC_W-1:0]         src,
  input  logic [SLOT_W-1:0]        cnt,
  output logic [NUM_VC*SRC_W-1:0]  shd_src,
  output logic [NUM_VC*SLOT_W-1:0] shd_cnt
);
  for (genvar g = 0; g < NUM_VC; g++) begin : g_ent
    logic hit;
    assign hit = we && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_src[g*SRC_W +: SRC_W]   <= '0;
        shd_cnt[g*SLOT_W +: SLOT_W] <= '0;
      end else if (hit) begin
        shd_src[g*SRC_W +: SRC_W]   <= src;
        shd_cnt[g*SLOT_W +: SLOT_W] <= cnt;
      end
    end
  end
endmodule

// File: rtl/sat_commit.sv
module sat_commit
  import sat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmd,
  input  logic       trig_done,
  input  logic       frame_edge,
  output logic       pending,
  output logic       trig_req,
  output logic       commit
);
  commit_st_e st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: begin
        if (upd_cmd_e'(cmd) == UPD_TRIG)        st_nx = ST_TRIG;
        else if (upd_cmd_e'(cmd) == UPD_DIRECT) st_nx = ST_ARM;
      end
      ST_TRIG: if (trig_done)  st_nx = ST_ARM;
      ST_ARM:  if (frame_edge) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign pending  = (st != ST_IDLE);
  assign trig_req = (st == ST_TRIG);
  assign commit   = (st == ST_ARM) && frame_edge;
endmodule

// File: rtl/sat_slot_map.sv
module sat_slot_map #(
  parameter int NUM_VC = 4,
  parameter int SRC_W  = 2,
  parameter int SLOT_W = 6,
  localparam int IDX_W = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int SUM_W = SLOT_W + IDX_W + 1,
  localparam int FRAME = 1 << SLOT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [NUM_VC*SRC_W-1:0]  shd_src,
  input  logic [NUM_VC*SLOT_W-1:0] shd_cnt,
  input  logic [SLOT_W-1:0]        slot_idx,
  output logic [NUM_VC*SRC_W-1:0]  act_src,
  output logic [NUM_VC*SLOT_W-1:0] act_cnt,
  output logic                     owner_vld,
  output logic [IDX_W-1:0]         owner_vc,
  output logic [SRC_W-1:0]         owner_src,
  output logic                     alloc_err
);
  // Clip a slot position to the frame end.
  function automatic logic [SUM_W-1:0] clip_pos(input logic [SUM_W-1:0] v);
    return (v > SUM_W'(FRAME)) ? SUM_W'(FRAME) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_src <= '0;
      act_cnt <= '0;
    end else if (commit) begin
      act_src <= shd_src;
      act_cnt <= shd_cnt;
    end
  end

  logic [SUM_W-1:0] lo [NUM_VC];
  logic [SUM_W-1:0] hi [NUM_VC];
  logic [SUM_W-1:0] total;

  always_comb begin
    logic [SUM_W-1:0] run;
    run = SUM_W'(1);
    for (int i = 0; i < NUM_VC; i++) begin
      lo[i] = clip_pos(run);
      run   = run + SUM_W'(act_cnt[i*SLOT_W +: SLOT_W]);
      hi[i] = clip_pos(run);
    end
    total = run - SUM_W'(1);
  end

  assign alloc_err = (total > SUM_W'(FRAME - 1));

  logic [NUM_VC-1:0] hit;
  for (genvar g = 0; g < NUM_VC; g++) begin : g_hit
    assign hit[g] = (SUM_W'(slot_idx) >= lo[g]) && (SUM_W'(slot_idx) < hi[g]);
  end

  always_comb begin
    owner_vld = 1'b0;
    owner_vc  = '0;
    owner_src = '0;
    for (int i = 0; i < NUM_VC; i++) begin
      if (hit[i] && !owner_vld) begin
        owner_vld = 1'b1;
        owner_vc  = IDX_W'(i);
        owner_src = act_src[i*SRC_W +: SRC_W];
      end
    end
  end
endmodule

// File: rtl/slot_alloc_table.sv
module slot_alloc_table #(
  parameter int NUM_VC = 4,
  parameter int SRC_W  = 2,
  parameter int SLOT_W = 6,
  localparam int IDX_W = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shd_we,
  input  logic [IDX_W-1:0]         shd_idx,
  input  logic [SRC_W-1:0]         shd_src,
  input  logic [SLOT_W-1:0]        shd_cnt,
  input  logic [1:0]               upd_cmd,
  input  logic                     trig_done,
  input  logic                     slot_adv,
  output logic                     pending,
  output logic                     trig_req,
  output logic [NUM_VC*SRC_W-1:0]  act_src,
  output logic [NUM_VC*SLOT_W-1:0] act_cnt,
  output logic [SLOT_W-1:0]        slot_idx,
  output logic                     hdr_slot,
  output logic                     owner_vld,
  output logic [IDX_W-1:0]         owner_vc,
  output logic [SRC_W-1:0]         owner_src,
  output logic                     alloc_err
);
  logic [NUM_VC*SRC_W-1:0]  sh_src;
  logic [NUM_VC*SLOT_W-1:0] sh_cnt;
  logic                     frame_edge;
  logic                     commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        slot_idx <= '0;
    else if (slot_adv) slot_idx <= slot_idx + SLOT_W'(1);
  end

  assign frame_edge = slot_adv && (slot_idx == '1);
  assign hdr_slot   = (slot_idx == '0);

  sat_shadow #(.NUM_VC(NUM_VC), .SRC_W(SRC_W), .SLOT_W(SLOT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .we(shd_we), .idx(shd_idx),
    .src(shd_src), .cnt(shd_cnt), .shd_src(sh_src), .shd_cnt(sh_cnt)
  );

  sat_commit u_commit (
    .clk(clk), .rst_n(rst_n), .cmd(upd_cmd), .trig_done(trig_done),
    .frame_edge(frame_edge), .pending(pending), .trig_req(trig_req),
    .commit(commit)
  );

  sat_slot_map #(.NUM_VC(NUM_VC), .SRC_W(SRC_W), .SLOT_W(SLOT_W)) u_map (
    .clk(clk), .rst_n(rst_n), .commit(commit), .shd_src(sh_src),
    .shd_cnt(sh_cnt), .slot_idx(slot_idx), .act_src(act_src),
    .act_cnt(act_cnt), .owner_vld(owner_vld), .owner_vc(owner_vc),
    .owner_src(owner_src), .alloc_err(alloc_err)
  );
endmodule

module slot_alloc_table_chk #(
  parameter int NUM_VC = 4,
  parameter int SRC_W  = 2,
  parameter int SLOT_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               upd_cmd,
  input logic                     trig_done,
  input logic                     slot_adv,
  input logic                     pending,
  input logic                     trig_req,
  input logic [NUM_VC*SRC_W-1:0]  act_src,
  input logic [NUM_VC*SLOT_W-1:0] act_cnt,
  input logic [SLOT_W-1:0]        slot_idx,
  input logic                     hdr_slot,
  input logic                     owner_vld,
  input logic                     commit
);
  // R5
  trig_under_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_req |-> pending);
  // R5
  trig_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_req) |-> $past(trig_done));
  // R6
  commit_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (slot_adv && slot_idx == '1 && !trig_req));
  // R4
  pending_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !pending);
  // R1
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_src) && $stable(act_cnt)));
  // R3
  pending_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> ($past(upd_cmd) == 2'd1 || $past(upd_cmd) == 2'd2));
  // R8
  header_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_slot |-> !owner_vld);
endmodule

bind slot_alloc_table slot_alloc_table_chk #(
  .NUM_VC(NUM_VC), .SRC_W(SRC_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_cmd(upd_cmd), .trig_done(trig_done),
  .slot_adv(slot_adv), .pending(pending), .trig_req(trig_req),
  .act_src(act_src), .act_cnt(act_cnt), .slot_idx(slot_idx),
  .hdr_slot(hdr_slot), .owner_vld(owner_vld), .commit(commit)
);

// File: tb/tb_slot_alloc_table.sv
module tb_slot_alloc_table;
  localparam int NV = 4;
  localparam int SW = 2;
  localparam int LW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shd_we = 1'b0;
  logic [1:0] shd_idx = '0;
  logic [SW-1:0] shd_src = '0;
  logic [LW-1:0] shd_cnt = '0;
  logic [1:0] upd_cmd = '0;
  logic trig_done = 1'b0;
  logic slot_adv = 1'b0;
  logic pending, trig_req, hdr_slot, owner_vld, alloc_err;
  logic [NV*SW-1:0] act_src;
  logic [NV*LW-1:0] act_cnt;
  logic [LW-1:0] slot_idx;
  logic [1:0] owner_vc;
  logic [SW-1:0] owner_src;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  slot_alloc_table dut (
    .clk(clk), .rst_n(rst_n), .shd_we(shd_we), .shd_idx(shd_idx),
    .shd_src(shd_src), .shd_cnt(shd_cnt), .upd_cmd(upd_cmd),
    .trig_done(trig_done), .slot_adv(slot_adv), .pending(pending),
    .trig_req(trig_req), .act_src(act_src), .act_cnt(act_cnt),
    .slot_idx(slot_idx), .hdr_slot(hdr_slot), .owner_vld(owner_vld),
    .owner_vc(owner_vc), .owner_src(owner_src), .alloc_err(alloc_err)
  );

  // Reference model: 0 idle, 1 waiting for trigger done, 2 armed.
  int m_ssrc [NV];
  int m_scnt [NV];
  int m_asrc [NV];
  int m_acnt [NV];
  int m_st   = 0;
  int m_slot = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NV; i++) begin
        m_ssrc[i] = 0; m_scnt[i] = 0; m_asrc[i] = 0; m_acnt[i] = 0;
      end
      m_st = 0; m_slot = 0;
    end else begin
      bit bnd;
      bnd = slot_adv && (m_slot == 63);
      case (m_st)
        0: if (upd_cmd == 2'd1) m_st = 1; else if (upd_cmd == 2'd2) m_st = 2;
        1: if (trig_done) m_st = 2;
        default: if (bnd) begin
          for (int i = 0; i < NV; i++) begin
            m_asrc[i] = m_ssrc[i]; m_acnt[i] = m_scnt[i];
          end
          m_st = 0;
        end
      endcase
      if (shd_we) begin
        m_ssrc[shd_idx] = int'(shd_src);
        m_scnt[shd_idx] = int'(shd_cnt);
      end
      if (slot_adv) m_slot = (m_slot + 1) % 64;
    end
  end

  // Walk the frame slot by slot to find the owner of slot s.
  function automatic int exp_owner(input int s, output int vc);
    int pos;
    pos = 1;
    vc = -1;
    for (int i = 0; i < NV; i++)
      for (int k = 0; k < m_acnt[i]; k++) begin
        if (pos == s && pos < 64) vc = i;
        pos++;
      end
    return (vc >= 0) ? m_asrc[vc] : -1;
  endfunction

  function automatic int exp_total();
    int t;
    t = 0;
    foreach (m_acnt[i]) t += m_acnt[i];
    return t;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    int ev, es;
    chk("R4", "pending", int'(pending), int'(m_st != 0));
    chk("R5", "trig_req", int'(trig_req), int'(m_st == 1));
    chk("R8", "slot_idx", int'(slot_idx), m_slot);
    chk("R8", "hdr_slot", int'(hdr_slot), int'(m_slot == 0));
    for (int i = 0; i < NV; i++) begin
      chk("R6", "act_src", int'(act_src[i*SW +: SW]), m_asrc[i]);
      chk("R1", "act_cnt", int'(act_cnt[i*LW +: LW]), m_acnt[i]);
    end
    es = exp_owner(m_slot, ev);
    chk("R9", "owner_vld", int'(owner_vld), int'(ev >= 0));
    if (ev >= 0) begin
      chk("R9", "owner_vc", int'(owner_vc), ev);
      chk("R9", "owner_src", int'(owner_src), es);
    end
    chk("R10", "alloc_err", int'(alloc_err), int'(exp_total() > 63));
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
    shd_we = 1'b0; upd_cmd = 2'd0; trig_done = 1'b0;
  endtask

  task automatic run_until_idle();
    for (int k = 0; k < 400 && (m_st != 0); k++) step();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R2: reset state
    chk("R2", "reset pending", int'(pending), 0);
    chk("R2", "reset act_cnt", int'(act_cnt), 0);
    chk("R2", "reset slot", int'(slot_idx), 0);
    slot_adv = 1'b1;
    // R1: fill shadow, total 70 slots overflows the frame
    for (int i = 0; i < NV; i++) begin
      shd_we = 1'b1; shd_idx = 2'(i); shd_src = SW'(i + 1); shd_cnt = (i == 3) ? 6'd10 : 6'd20;
      step();
    end
    chk("R1", "shadow hidden", int'(act_cnt), 0);
    upd_cmd = 2'd3;
    step();
    step();
    // R3: reserved code takes no action
    chk("R3", "cmd3 pending", int'(pending), 0);
    upd_cmd = 2'd2;
    step();
    chk("R4", "pending after cmd2", int'(pending), 1);
    upd_cmd = 2'd1;
    step();
    // R7: command while pending ignored
    chk("R7", "trig_req stays low", int'(trig_req), 0);
    run_until_idle();
    chk("R10", "clipped overflow err", int'(alloc_err), 1);
    // trigger path
    shd_we = 1'b1; shd_idx = 2'd3; shd_cnt = 6'd3;
    step();
    upd_cmd = 2'd1;
    step();
    for (int k = 0; k < 80; k++) begin
      chk("R5", "trig held", int'(trig_req), 1);
      step();
    end
    trig_done = 1'b1;
    step();
    run_until_idle();
    chk("R6", "cnt after trigger commit", int'(act_cnt[3*LW +: LW]), 3);
    // constrained random phase
    for (int c = 0; c < 12000; c++) begin
      int r;
      slot_adv = ($urandom % 8) != 0;
      if (m_st == 0 && ($urandom % 3) == 0) begin
        shd_we = 1'b1;
        shd_idx = 2'($urandom % NV);
        shd_src = SW'($urandom);
        r = $urandom % 10;
        shd_cnt = (r == 0) ? 6'd0 : (r == 1) ? 6'd63 : LW'($urandom % 30);
      end
      r = $urandom % 40;
      upd_cmd = (r < 36) ? 2'd0 : 2'(r - 36);
      if (m_st == 1 && ($urandom % 30) == 0) trig_done = 1'b1;
      else if (($urandom % 50) == 0) trig_done = 1'b1;
      step();
    end
    done_flag = 1;
    summary();
  end
endmodule